// File: doc/BRIEF.md
# Calendar Counter with Coherent Read Snapshot

This block keeps wall-clock time from a free-running oscillator clock. It counts hundredths of a second, seconds, minutes and hours, then day of month, month, a two-digit year and a day of the week. A fractional prescaler turns any of four oscillator rates into exactly one hundred hundredth-ticks per second. A byte-wide register port reaches each time field by offset, and a write-only command byte starts and stops counting, picks the 12- or 24-hour hour format, selects the oscillator rate, and can force a test mode that advances the counters on every clock.

Software reads the time by first reading the hundredths byte. That read returns the live hundredths value and copies every other field into a shadow latch in the same clock edge. Later reads of the other fields return the shadow, so a multi-byte read is never torn by a carry. The shadow changes only on the next hundredths read. Alarm matching and interrupt generation live in a neighbouring block.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset the time reads hundredths 0, second 0, minute 0, hour 0, day 1, month 1, year 0, weekday 0. The command state is stopped, 24-hour format, oscillator select 0 and test mode off.
- R2: Field offsets are 0 hundredths, 1 hour, 2 minute, 3 second, 4 month, 5 day, 6 year, 7 weekday. A read is registered: rdata_o carries the value in the cycle after rd_en_i.
- R3: A read of offset 0 returns the live hundredths value and, in the same edge, captures all other fields into a shadow. Reads of offsets 1 to 7 return the shadow, which holds until offset 0 is read again.
- R4: The command byte sits at offset 8 and is write-only, so reads of offset 8 return 0. Its bits are: bit 5 test mode, bit 3 run (1 = counting), bit 2 hour format (1 = 24-hour, 0 = 12-hour) and bits 1:0 oscillator select.
- R5: Oscillator select 0, 1, 2 and 3 mean 32 768 Hz, 1 048 576 Hz, 2 097 152 Hz and 4 194 304 Hz. After N clock cycles of running from a cleared phase, floor(N*100/f) hundredth-ticks have occurred. No tick occurs while stopped, and the phase is kept across a stop.
- R6: With test mode and run set, the counters advance by one hundredth on every clock cycle.
- R7: The ranges are hundredths 0..99, seconds and minutes 0..59, and 24-hour hours 0..23. Each field wraps to its minimum and carries into the next. Year 99 wraps to 0, so at the last hundredth of 23:59:59 on day 31 of month 12 of year 99 every field returns to its minimum.
- R8: Months 4, 6, 9 and 11 have 30 days. February has 29 days when year mod 4 is 0 and 28 otherwise. All other months have 31 days. Past the last day, the day becomes 1 and the month advances.
- R9: The weekday advances by one on each day rollover and wraps from 6 to 0.
- R10: In 12-hour mode the hour byte holds 1..12 in bits 4:0, with bit 7 set for PM. The hour runs 11 AM (0x0B) to 12 PM (0x8C), 12 PM to 1 PM (0x81), and 11 PM (0x8B) to 12 AM (0x0C). Only the last of these starts a new day.
- R11: A write to offsets 0 to 7 loads the field only while stopped; while running it is ignored. A stopped write to offset 0 also clears the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A read of the hundredths byte can land on the same edge as a tick that carries the hundredths from 99 into the seconds. To provoke this, the bench preloads hundredths 99 and a known second, sets run and test mode, and reads offset 0 on the very next cycle, then stops the clock one cycle later. The read must return 99. The shadowed second must show the pre-carry value, even though the live counter has already moved twice. A second offset-0 read must then expose the live values that the bench counted.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int FIELD_W    = 8;
  localparam int ADDR_W     = 4;
  localparam int NUM_FIELDS = 8;
  localparam int IDX_W      = $clog2(NUM_FIELDS);
  localparam int OSC_SEL_W  = 2;

  localparam logic [FIELD_W-1:0] HSEC_MAX   = 8'd99;
  localparam logic [FIELD_W-1:0] SEC_MAX    = 8'd59;
  localparam logic [FIELD_W-1:0] MIN_MAX    = 8'd59;
  localparam logic [FIELD_W-1:0] HOUR24_MAX = 8'd23;
  localparam logic [FIELD_W-1:0] MON_MAX    = 8'd12;
  localparam logic [FIELD_W-1:0] YEAR_MAX   = 8'd99;
  localparam logic [FIELD_W-1:0] WDAY_MAX   = 8'd6;
  localparam int PM_BIT = 7;

  typedef enum logic [ADDR_W-1:0] {
    OFS_HSEC = 4'd0, OFS_HOUR = 4'd1, OFS_MIN  = 4'd2, OFS_SEC = 4'd3,
    OFS_MON  = 4'd4, OFS_DAY  = 4'd5, OFS_YEAR = 4'd6, OFS_WDAY = 4'd7,
    OFS_CMD  = 4'd8
  } ofs_e;

  typedef struct packed {
    logic [FIELD_W-1:0] hsec;
    logic [FIELD_W-1:0] sec;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] hour;
    logic [FIELD_W-1:0] day;
    logic [FIELD_W-1:0] mon;
    logic [FIELD_W-1:0] year;
    logic [FIELD_W-1:0] wday;
  } cal_t;

  typedef struct packed {
    logic                 test;
    logic                 run;
    logic                 fmt24;
    logic [OSC_SEL_W-1:0] osc;
  } cmd_t;

  localparam cal_t CAL_RESET = '{hsec: 8'd0, sec: 8'd0, min: 8'd0, hour: 8'd0,
                                 day: 8'd1, mon: 8'd1, year: 8'd0, wday: 8'd0};
  localparam cmd_t CMD_RESET = '{test: 1'b0, run: 1'b0, fmt24: 1'b1, osc: '0};

  function automatic logic [FIELD_W-1:0] field_mask(logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 8'h7f;
      3'd1:    return 8'h9f;
      3'd2,
      3'd3:    return 8'h3f;
      3'd4:    return 8'h0f;
      3'd5:    return 8'h1f;
      3'd6:    return 8'h7f;
      default: return 8'h07;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] get_field(cal_t t, logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return t.hsec;
      3'd1:    return t.hour;
      3'd2:    return t.min;
      3'd3:    return t.sec;
      3'd4:    return t.mon;
      3'd5:    return t.day;
      3'd6:    return t.year;
      default: return t.wday;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] days_in_month(logic [FIELD_W-1:0] mon,
                                                       logic [FIELD_W-1:0] year);
    case (mon)
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      8'd2:                    return (year[1:0] == 2'd0) ? 8'd29 : 8'd28;
      default:                 return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int LOW_OSC_HZ    = 32768,
  parameter int HIGH_OSC_HZ   = 1048576,
  parameter int TICKS_PER_SEC = 100
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            run_i,
  input  logic                            test_i,
  input  logic                            clr_i,
  input  logic [rtc_cal_pkg::OSC_SEL_W-1:0] osc_i,
  output logic                            tick_o
);
  localparam int NUM_OSC = 1 << rtc_cal_pkg::OSC_SEL_W;
  localparam int MAX_HZ  = HIGH_OSC_HZ << (NUM_OSC - 2);
  localparam int ACC_W   = $clog2(MAX_HZ) + 1;

  logic [ACC_W-1:0] mod_tbl [NUM_OSC];
  logic [ACC_W-1:0] acc_q, sum, modulus;
  logic             hit;

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_mod
    if (g == 0) begin : g_low
      assign mod_tbl[g] = ACC_W'(LOW_OSC_HZ);
    end else begin : g_high
      assign mod_tbl[g] = ACC_W'(HIGH_OSC_HZ << (g - 1));
    end
  end

  assign modulus = mod_tbl[osc_i];
  assign sum     = acc_q + ACC_W'(TICKS_PER_SEC);
  assign hit     = sum >= modulus;
  assign tick_o  = run_i & (test_i | hit);

  // fractional accumulator: exact tick count per second for any modulus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               acc_q <= '0;
    else if (clr_i)            acc_q <= '0;
    else if (run_i && !test_i) acc_q <= hit ? sum - modulus : sum;
  end
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 fmt24_i,
  input  logic                 ld_i,
  input  logic [IDX_W-1:0]     ld_idx_i,
  input  logic [FIELD_W-1:0]   ld_data_i,
  output cal_t                 cal_o
);
  cal_t               cal_q, cal_d;
  logic               day_carry;
  logic [4:0]         h12;
  logic [FIELD_W-1:0] ld_val;

  assign ld_val = ld_data_i & field_mask(ld_idx_i);
  assign h12    = cal_q.hour[4:0];

  always_comb begin
    cal_d     = cal_q;
    day_carry = 1'b0;
    if (ld_i) begin
      case (ld_idx_i)
        3'd0:    cal_d.hsec = ld_val;
        3'd1:    cal_d.hour = ld_val;
        3'd2:    cal_d.min  = ld_val;
        3'd3:    cal_d.sec  = ld_val;
        3'd4:    cal_d.mon  = ld_val;
        3'd5:    cal_d.day  = ld_val;
        3'd6:    cal_d.year = ld_val;
        default: cal_d.wday = ld_val;
      endcase
    end else if (tick_i) begin
      if (cal_q.hsec != HSEC_MAX) cal_d.hsec = cal_q.hsec + 8'd1;
      else begin
        cal_d.hsec = '0;
        if (cal_q.sec != SEC_MAX) cal_d.sec = cal_q.sec + 8'd1;
        else begin
          cal_d.sec = '0;
          if (cal_q.min != MIN_MAX) cal_d.min = cal_q.min + 8'd1;
          else begin
            cal_d.min = '0;
            if (fmt24_i) begin
              if (cal_q.hour == HOUR24_MAX) begin
                cal_d.hour = '0;
                day_carry  = 1'b1;
              end else cal_d.hour = cal_q.hour + 8'd1;
            end else begin
              // 12-hour: PM flag flips entering 12, day starts at 12 AM
              if (h12 == 5'd11) begin
                cal_d.hour = {~cal_q.hour[PM_BIT], 7'd12};
                day_carry  = cal_q.hour[PM_BIT];
              end else if (h12 == 5'd12) begin
                cal_d.hour = {cal_q.hour[PM_BIT], 7'd1};
              end else begin
                cal_d.hour = {cal_q.hour[PM_BIT], 2'b00, h12 + 5'd1};
              end
            end
          end
        end
      end
      if (day_carry) begin
        cal_d.wday = (cal_q.wday == WDAY_MAX) ? '0 : cal_q.wday + 8'd1;
        if (cal_q.day != days_in_month(cal_q.mon, cal_q.year)) cal_d.day = cal_q.day + 8'd1;
        else begin
          cal_d.day = 8'd1;
          if (cal_q.mon != MON_MAX) cal_d.mon = cal_q.mon + 8'd1;
          else begin
            cal_d.mon  = 8'd1;
            cal_d.year = (cal_q.year == YEAR_MAX) ? '0 : cal_q.year + 8'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cal_q <= CAL_RESET;
    else         cal_q <= cal_d;
  end

  assign cal_o = cal_q;
endmodule

// File: rtl/rtc_read_latch.sv
module rtc_read_latch
  import rtc_cal_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  cal_t                cal_i,
  output cal_t                shadow_o,
  output logic [FIELD_W-1:0]  rdata_o
);
  cal_t               shadow_q;
  logic [FIELD_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= CAL_RESET;
      rdata_q  <= '0;
    end else if (rd_i) begin
      if (addr_i == OFS_HSEC) begin
        shadow_q <= cal_i;
        rdata_q  <= cal_i.hsec;
      end else if (addr_i < ADDR_W'(NUM_FIELDS)) begin
        rdata_q  <= get_field(shadow_q, addr_i[IDX_W-1:0]);
      end else begin
        rdata_q  <= '0;
      end
    end
  end

  assign shadow_o = shadow_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
  import rtc_cal_pkg::*;
#(
  parameter int LOW_OSC_HZ    = 32768,
  parameter int HIGH_OSC_HZ   = 1048576,
  parameter int TICKS_PER_SEC = 100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [FIELD_W-1:0] wdata_i,
  output logic [FIELD_W-1:0] rdata_o
);
  cmd_t cmd_q;
  cal_t cal_q;
  cal_t shadow;
  logic tick, field_wr, ld, clr_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= CMD_RESET;
    else if (wr_en_i && addr_i == OFS_CMD)
      cmd_q <= '{test: wdata_i[5], run: wdata_i[3], fmt24: wdata_i[2], osc: wdata_i[1:0]};
  end

  assign field_wr  = wr_en_i && (addr_i < ADDR_W'(NUM_FIELDS));
  assign ld        = field_wr && !cmd_q.run;
  assign clr_phase = ld && (addr_i == OFS_HSEC);

  rtc_prescaler #(
    .LOW_OSC_HZ   (LOW_OSC_HZ),
    .HIGH_OSC_HZ  (HIGH_OSC_HZ),
    .TICKS_PER_SEC(TICKS_PER_SEC)
  ) i_prescaler (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (cmd_q.run),
    .test_i(cmd_q.test),
    .clr_i (clr_phase),
    .osc_i (cmd_q.osc),
    .tick_o(tick)
  );

  rtc_time_chain i_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .fmt24_i  (cmd_q.fmt24),
    .ld_i     (ld),
    .ld_idx_i (addr_i[IDX_W-1:0]),
    .ld_data_i(wdata_i),
    .cal_o    (cal_q)
  );

  rtc_read_latch i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_en_i),
    .addr_i  (addr_i),
    .cal_i   (cal_q),
    .shadow_o(shadow),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               rd_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [FIELD_W-1:0] rdata_o,
  input logic               run_i,
  input logic               fmt24_i,
  input logic               tick_i,
  input cal_t               cur_i,
  input cal_t               shd_i
);
  p_tick_needs_run_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> run_i);

  p_hold_when_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_en_i) |=> $stable(cur_i));

  p_hsec_read_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_HSEC) |=> rdata_o == $past(cur_i.hsec));

  p_shadow_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_i && addr_i == OFS_HSEC) |=> $stable(shd_i));

  p_hsec_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cur_i.hsec == 8'd99) |=> cur_i.hsec == 8'd0);

  p_noon_flip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !fmt24_i && cur_i.hour == 8'h0B && cur_i.hsec == 8'd99 &&
     cur_i.sec == 8'd59 && cur_i.min == 8'd59) |=> cur_i.hour == 8'h8C);
endmodule

bind rtc_calendar_top rtc_calendar_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .run_i  (cmd_q.run),
  .fmt24_i(cmd_q.fmt24),
  .tick_i (tick),
  .cur_i  (cal_q),
  .shd_i  (shadow)
);

// File: tb/test_rtc_calendar_top.sv
module test_rtc_calendar_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  rtc_calendar_top i_rtc_calendar_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    n_chk++;
    if (v !== exp) begin
      n_fail++;
      $display("FAIL %s offset %0d actual 0x%02h expected 0x%02h", tag, a, v, exp);
    end
  endtask

  task automatic load_time(input logic [7:0] hs, s, m, h, dy, mo, yr, wd);
    wr(4'd0, hs); wr(4'd3, s); wr(4'd2, m); wr(4'd1, h);
    wr(4'd5, dy); wr(4'd4, mo); wr(4'd6, yr); wr(4'd7, wd);
  endtask

  // one running edge in test mode, then stop
  task automatic pulse(input logic fmt24);
    wr(4'd8, {2'b00, 1'b1, 1'b0, 1'b1, fmt24, 2'b00});
    wr(4'd8, {5'b00000, fmt24, 2'b00});
  endtask

  task automatic t_reset;
    chk("R1 hsec", 4'd0, 8'd0);
    chk("R1 hour", 4'd1, 8'd0);
    chk("R1 min", 4'd2, 8'd0);
    chk("R1 sec", 4'd3, 8'd0);
    chk("R1 mon", 4'd4, 8'd1);
    chk("R1 day", 4'd5, 8'd1);
    chk("R1 year", 4'd6, 8'd0);
    chk("R2 wday", 4'd7, 8'd0);
    chk("R4 cmd read", 4'd8, 8'd0);
  endtask

  task automatic t_year_end;
    load_time(8'd99, 8'd59, 8'd59, 8'd23, 8'd31, 8'd12, 8'd99, 8'd6);
    pulse(1'b1);
    chk("R6 hsec", 4'd0, 8'd0);
    chk("R7 sec", 4'd3, 8'd0);
    chk("R7 min", 4'd2, 8'd0);
    chk("R7 hour", 4'd1, 8'd0);
    chk("R7 day", 4'd5, 8'd1);
    chk("R7 mon", 4'd4, 8'd1);
    chk("R7 year", 4'd6, 8'd0);
    chk("R9 wday", 4'd7, 8'd0);
  endtask

  task automatic t_months;
    load_time(8'd99, 8'd59, 8'd59, 8'd23, 8'd28, 8'd2, 8'd4, 8'd1);
    pulse(1'b1);
    chk("R8 leap hsec", 4'd0, 8'd0);
    chk("R8 leap day29", 4'd5, 8'd29);
    chk("R8 leap mon", 4'd4, 8'd2);
    chk("R9 wday inc", 4'd7, 8'd2);
    load_time(8'd99, 8'd59, 8'd59, 8'd23, 8'd29, 8'd2, 8'd4, 8'd2);
    pulse(1'b1);
    chk("R8 leap end hsec", 4'd0, 8'd0);
    chk("R8 leap end day", 4'd5, 8'd1);
    chk("R8 leap end mon", 4'd4, 8'd3);
    load_time(8'd99, 8'd59, 8'd59, 8'd23, 8'd28, 8'd2, 8'd5, 8'd3);
    pulse(1'b1);
    chk("R8 common hsec", 4'd0, 8'd0);
    chk("R8 common day", 4'd5, 8'd1);
    chk("R8 common mon", 4'd4, 8'd3);
    load_time(8'd99, 8'd59, 8'd59, 8'd23, 8'd30, 8'd4, 8'd5, 8'd3);
    pulse(1'b1);
    chk("R8 30day hsec", 4'd0, 8'd0);
    chk("R8 30day day", 4'd5, 8'd1);
    chk("R8 30day mon", 4'd4, 8'd5);
    load_time(8'd99, 8'd59, 8'd59, 8'd23, 8'd30, 8'd5, 8'd5, 8'd3);
    pulse(1'b1);
    chk("R8 31day hsec", 4'd0, 8'd0);
    chk("R8 31day day", 4'd5, 8'd31);
  endtask

  task automatic t_twelve;
    wr(4'd8, 8'h00);
    load_time(8'd99, 8'd59, 8'd59, 8'h0B, 8'd10, 8'd1, 8'd1, 8'd2);
    pulse(1'b0);
    chk("R10 noon hsec", 4'd0, 8'd0);
    chk("R10 11AM to 12PM", 4'd1, 8'h8C);
    chk("R10 noon same day", 4'd5, 8'd10);
    load_time(8'd99, 8'd59, 8'd59, 8'h8C, 8'd10, 8'd1, 8'd1, 8'd2);
    pulse(1'b0);
    chk("R10 1pm hsec", 4'd0, 8'd0);
    chk("R10 12PM to 1PM", 4'd1, 8'h81);
    load_time(8'd99, 8'd59, 8'd59, 8'h8B, 8'd10, 8'd1, 8'd1, 8'd2);
    pulse(1'b0);
    chk("R10 midnight hsec", 4'd0, 8'd0);
    chk("R10 11PM to 12AM", 4'd1, 8'h0C);
    chk("R10 new day", 4'd5, 8'd11);
    chk("R9 wday 12h", 4'd7, 8'd3);
    wr(4'd8, 8'h04);
  endtask

  task automatic t_prescale;
    // 32.768 kHz: 32768 running cycles give exactly 100 ticks
    load_time(8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0);
    wr(4'd8, 8'h0C);
    repeat (32767) @(negedge clk);
    wr(4'd8, 8'h04);
    chk("R5 32k hsec", 4'd0, 8'd0);
    chk("R5 32k sec", 4'd3, 8'd1);
    // running writes ignored: 3 running cycles, no tick
    wr(4'd8, 8'h0C);
    wr(4'd3, 8'd30);
    wr(4'd0, 8'd50);
    wr(4'd8, 8'h04);
    chk("R11 hsec kept", 4'd0, 8'd0);
    chk("R11 sec kept", 4'd3, 8'd1);
    // 1.048576 MHz: 10485 cycles no tick, 10486th gives one
    wr(4'd8, 8'h05);
    wr(4'd0, 8'd0);
    wr(4'd8, 8'h0D);
    repeat (10484) @(negedge clk);
    wr(4'd8, 8'h05);
    chk("R5 1M before", 4'd0, 8'd0);
    wr(4'd8, 8'h0D);
    wr(4'd8, 8'h05);
    chk("R5 1M after", 4'd0, 8'd1);
    wr(4'd8, 8'h04);
  endtask

  task automatic t_coherent;
    logic [7:0] v;
    load_time(8'd99, 8'd5, 8'd0, 8'd0, 8'd1, 8'd1, 8'd0, 8'd0);
    wr(4'd8, 8'h2C);
    rd(4'd0, v);         // same edge as a tick carrying into seconds
    wr(4'd8, 8'h04);
    n_chk++;
    if (v !== 8'd99) begin
      n_fail++;
      $display("FAIL R3 coincident hsec actual 0x%02h expected 0x%02h", v, 8'd99);
    end
    chk("R3 shadow sec", 4'd3, 8'd5);
    chk("R3 shadow again", 4'd3, 8'd5);
    chk("R3 live hsec", 4'd0, 8'd1);
    chk("R3 new shadow sec", 4'd3, 8'd6);
    chk("R4 cmd write-only", 4'd8, 8'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_year_end;
    t_months;
    t_twelve;
    t_prescale;
    t_coherent;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule